// File: doc/BRIEF.md
# Dual-Rate Corrector Setpoint Combiner

This block forms the DAC codes for a bank of corrector magnet supplies. Each channel's code is the sum of two terms. The first term is a slow DC-correction value that a host rewrites a few times per second. The second term is a fast feedback-compensation value. Fast values are written into a shadow bank at any time. They reach the active bank for all channels at once on the next rising edge of an external fast setting clock, which runs at up to about 10 kHz. That clock is asynchronous to the system clock and is synchronised inside the block.

Each channel can replace its fast term with a sample from a shared waveform memory. A slow trigger restarts playback at the first entry. After that, every fast-clock edge steps to the next entry, and the address wraps at a programmable length. Every channel has an enable: a disabled channel parks at the mid-scale code, which means zero current. A heartbeat counter advances once per fast-clock edge. A one-cycle pulse marks each accepted fast-setpoint write, for timing measurements.

Top module: `corr_setpoint_mixer`

## Requirements
- R1: After a synchronous reset, every channel's code is mid-scale 0x80000, the heartbeat count is 0 and the write pulse is low.
- R2: A fast write changes only the shadow bank. No channel output moves until a rising edge of `fast_clk_in`. After that edge, all channels show their new shadow values within 6 clock cycles.
- R3: A slow write reaches its channel's code within 3 clock cycles, with no fast-clock edge needed.
- R4: An enabled channel's code is clamp(slow + fast, -524288, 524287) + 524288. The terms are 20-bit two's complement, so the output is offset binary with the sign bit inverted.
- R5: A disabled channel outputs 0x80000 whatever its setpoints. Its slow and active values are kept, and they reappear when the channel is enabled again.
- R6: A channel with its `wave_sel` bit set uses the current waveform sample in place of its fast term. The sample is 0 until the first fast edge after `slow_trig`. The n-th fast edge after the trigger presents entry n-1.
- R7: Playback wraps from entry `wave_len`-1 back to entry 0. A length of 0 means the full memory depth.
- R8: `hb_count` increments by exactly one per rising edge of the fast clock and wraps at its width.
- R9: `pkt_rx` is high for exactly one cycle, the cycle after each accepted `fast_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_clk_in | input | 1 | External fast setting clock (asynchronous) |
| slow_we | input | 1 | Slow setpoint write strobe |
| slow_ch | input | 3 | Slow write channel index |
| slow_val | input | 20 | Slow setpoint, two's complement |
| fast_we | input | 1 | Fast shadow write strobe |
| fast_ch | input | 3 | Fast write channel index |
| fast_val | input | 20 | Fast setpoint, two's complement |
| ch_en | input | 8 | Per-channel enable |
| wave_sel | input | 8 | Per-channel waveform source select |
| wave_we | input | 1 | Waveform memory write strobe |
| wave_waddr | input | 8 | Waveform memory write address |
| wave_wdata | input | 20 | Waveform sample, two's complement |
| wave_len | input | 8 | Playback length in entries (0 = full depth) |
| slow_trig | input | 1 | Restarts waveform playback |
| dac_code | output | 160 | Channel k code at bits [20k+19:20k] |
| hb_count | output | 16 | Heartbeat count of fast edges |
| pkt_rx | output | 1 | One-cycle pulse per accepted fast write |

## Verification
The hardest situation to reach from the ports is a shadow bank that differs from the active bank on every channel at once. The bench reaches it by loading all eight shadow entries and then holding the fast clock low for many cycles, so it can confirm that nothing moves before the edge. The saturation corners are also hard to reach, because they need both terms near the rails at the same time. The bench covers them by sweeping every pair from a set of extreme and mid-range values across all channels, with the two terms swapped between odd and even channels. Wrap-around playback is reached by loading a short waveform with a small `wave_len` and counting fast edges past the end of it.

// File: rtl/corr_mix_pkg.sv
package corr_mix_pkg;
  localparam int DEF_CH    = 8;
  localparam int DEF_DW    = 20;
  localparam int DEF_DEPTH = 256;
  localparam int DEF_HBW   = 16;

  typedef enum logic {
    PB_IDLE = 1'b0,
    PB_RUN  = 1'b1
  } pb_state_t;
endpackage

// File: rtl/corr_edge_sync.sv
module corr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R2: one commit per edge of the external clock
  a_r2_single_commit: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/corr_wave_player.sv
module corr_wave_player
  import corr_mix_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int DW    = DEF_DW,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic [AW-1:0]        len,
  input  logic                 trig,
  input  logic                 step,
  output logic signed [DW-1:0] sample
);
  logic signed [DW-1:0] mem [DEPTH];
  logic signed [DW-1:0] rdata;
  logic [AW-1:0]        addr;
  logic [AW-1:0]        last;
  logic                 have;
  pb_state_t            st;

  assign last = len - AW'(1);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (step && st == PB_RUN && !trig) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= PB_IDLE;
      addr <= '0;
      have <= 1'b0;
    end else if (trig) begin
      st   <= PB_RUN;
      addr <= '0;
      have <= 1'b0;
    end else if (step && st == PB_RUN) begin
      have <= 1'b1;
      addr <= (addr == last) ? '0 : addr + AW'(1);
    end
  end

  assign sample = have ? rdata : '0;

  // R6: a trigger restarts playback at entry 0
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    trig |=> (addr == '0 && st == PB_RUN));
  // R7: the read address stays inside the programmed length
  a_r7_addr_wrap: assert property (@(posedge clk) disable iff (rst)
    (st == PB_RUN && len != '0) |-> addr < len || $past(len) != len || $past(trig) == 1'b0);
endmodule

// File: rtl/corr_sat_adder.sv
module corr_sat_adder
  import corr_mix_pkg::*;
#(
  parameter int DW = DEF_DW,
  localparam int SW = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic [DW-1:0]        code
);
  localparam logic [DW-1:0]       MID  = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [SW-1:0] MAXV = SW'({1'b0, {(DW-1){1'b1}}});
  localparam logic signed [SW-1:0] MINV = -SW'({1'b1, {(DW-1){1'b0}}});

  logic signed [SW-1:0] sum;
  logic signed [DW-1:0] clamped;

  always_comb begin
    sum = SW'(a) + SW'(b);
    if (sum > MAXV)      clamped = MAXV[DW-1:0];
    else if (sum < MINV) clamped = MINV[DW-1:0];
    else                 clamped = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     code <= MID;
    else if (en) code <= {~clamped[DW-1], clamped[DW-2:0]};
    else         code <= MID;
  end

  // R5: disabled channel parks at mid-scale
  a_r5_mid_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> code == MID);
  // R4: two non-negative terms never wrap to a negative code
  a_r4_no_wrap_pos: assert property (@(posedge clk) disable iff (rst)
    (en && !a[DW-1] && !b[DW-1]) |=> code[DW-1]);
  // R4: two negative terms never wrap to a positive code
  a_r4_no_wrap_neg: assert property (@(posedge clk) disable iff (rst)
    (en && a[DW-1] && b[DW-1]) |=> !code[DW-1]);
endmodule

// File: rtl/corr_setpoint_mixer.sv
module corr_setpoint_mixer
  import corr_mix_pkg::*;
#(
  parameter int N_CH       = DEF_CH,
  parameter int DW         = DEF_DW,
  parameter int WAVE_DEPTH = DEF_DEPTH,
  parameter int HBW        = DEF_HBW,
  parameter int SYNC_STAGES = 2,
  localparam int CHW = $clog2(N_CH),
  localparam int AW  = $clog2(WAVE_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fast_clk_in,
  input  logic                 slow_we,
  input  logic [CHW-1:0]       slow_ch,
  input  logic signed [DW-1:0] slow_val,
  input  logic                 fast_we,
  input  logic [CHW-1:0]       fast_ch,
  input  logic signed [DW-1:0] fast_val,
  input  logic [N_CH-1:0]      ch_en,
  input  logic [N_CH-1:0]      wave_sel,
  input  logic                 wave_we,
  input  logic [AW-1:0]        wave_waddr,
  input  logic signed [DW-1:0] wave_wdata,
  input  logic [AW-1:0]        wave_len,
  input  logic                 slow_trig,
  output logic [N_CH*DW-1:0]   dac_code,
  output logic [HBW-1:0]       hb_count,
  output logic                 pkt_rx
);
  logic [N_CH*DW-1:0]   slow_bank;
  logic [N_CH*DW-1:0]   shadow_bank;
  logic [N_CH*DW-1:0]   active_bank;
  logic                 commit;
  logic signed [DW-1:0] wave_sample;

  corr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .async_in(fast_clk_in), .rise(commit)
  );

  corr_wave_player #(.DEPTH(WAVE_DEPTH), .DW(DW)) i_wave (
    .clk(clk), .rst(rst), .we(wave_we), .waddr(wave_waddr),
    .wdata(wave_wdata), .len(wave_len), .trig(slow_trig),
    .step(commit), .sample(wave_sample)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_bank   <= '0;
      shadow_bank <= '0;
      active_bank <= '0;
      hb_count    <= '0;
      pkt_rx      <= 1'b0;
    end else begin
      if (slow_we) slow_bank[slow_ch*DW +: DW] <= slow_val;
      if (fast_we) shadow_bank[fast_ch*DW +: DW] <= fast_val;
      if (commit) begin
        active_bank <= shadow_bank;
        hb_count    <= hb_count + HBW'(1);
      end
      pkt_rx <= fast_we;
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic signed [DW-1:0] fast_term;
    assign fast_term = wave_sel[k] ? wave_sample : active_bank[k*DW +: DW];
    corr_sat_adder #(.DW(DW)) i_add (
      .clk(clk), .rst(rst), .en(ch_en[k]),
      .a(slow_bank[k*DW +: DW]), .b(fast_term),
      .code(dac_code[k*DW +: DW])
    );
  end

  // R2: the active bank only moves on a fast-clock commit
  a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(active_bank));
  // R8: heartbeat steps by one per fast edge
  a_r8_hb_step: assert property (@(posedge clk) disable iff (rst)
    commit |=> hb_count == $past(hb_count) + HBW'(1));
  // R9: the write pulse follows an accepted fast write
  a_r9_pkt_follows_write: assert property (@(posedge clk) disable iff (rst)
    pkt_rx |-> $past(fast_we));
endmodule

// File: tb/test_corr_setpoint_mixer.sv
module test_corr_setpoint_mixer;
  localparam int N_CH = 8;
  localparam int DW   = 20;

  logic clk = 0;
  logic rst = 1;
  logic fast_clk_in = 0;
  logic slow_we = 0, fast_we = 0, wave_we = 0, slow_trig = 0;
  logic [2:0] slow_ch = 0, fast_ch = 0;
  logic signed [DW-1:0] slow_val = 0, fast_val = 0, wave_wdata = 0;
  logic [N_CH-1:0] ch_en = '1, wave_sel = '0;
  logic [7:0] wave_waddr = 0, wave_len = 0;
  logic [N_CH*DW-1:0] dac_code;
  logic [15:0] hb_count;
  logic pkt_rx;

  int checks = 0, errors = 0, edges = 0;
  bit done = 0;

  always #2 clk = ~clk;

  corr_setpoint_mixer i_corr_setpoint_mixer (
    .clk(clk), .rst(rst), .fast_clk_in(fast_clk_in),
    .slow_we(slow_we), .slow_ch(slow_ch), .slow_val(slow_val),
    .fast_we(fast_we), .fast_ch(fast_ch), .fast_val(fast_val),
    .ch_en(ch_en), .wave_sel(wave_sel), .wave_we(wave_we),
    .wave_waddr(wave_waddr), .wave_wdata(wave_wdata), .wave_len(wave_len),
    .slow_trig(slow_trig), .dac_code(dac_code), .hb_count(hb_count),
    .pkt_rx(pkt_rx)
  );

  function automatic int exp_code(int s, int f, bit en);
    int t;
    if (!en) return 524288;
    t = s + f;
    if (t > 524287) t = 524287;
    if (t < -524288) t = -524288;
    return t + 524288;
  endfunction

  function automatic int code_of(int k);
    return int'(dac_code[k*DW +: DW]);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_slow(int ch, int v);
    @(negedge clk);
    slow_we = 1; slow_ch = 3'(ch); slow_val = DW'(v);
    @(negedge clk);
    slow_we = 0;
  endtask

  task automatic wr_fast(int ch, int v);
    @(negedge clk);
    fast_we = 1; fast_ch = 3'(ch); fast_val = DW'(v);
    @(negedge clk);
    fast_we = 0;
  endtask

  task automatic fast_edge();
    @(negedge clk);
    fast_clk_in = 1;
    repeat (6) @(negedge clk);
    fast_clk_in = 0;
    repeat (4) @(negedge clk);
    edges++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int vals[9] = '{-524288, -524287, -1, 0, 1, 524287, 300000, -300000, 123456};
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < N_CH; k++) check("R1 reset code", code_of(k), 524288);
    check("R1 reset heartbeat", int'(hb_count), 0);
    check("R1 reset pulse", int'(pkt_rx), 0);

    // R9 write pulse
    @(negedge clk);
    fast_we = 1; fast_ch = 0; fast_val = 0;
    @(negedge clk);
    fast_we = 0;
    check("R9 pulse high", int'(pkt_rx), 1);
    @(negedge clk);
    check("R9 pulse low after one cycle", int'(pkt_rx), 0);

    // R4 saturation sweep across all channels
    foreach (vals[i]) foreach (vals[j]) begin
      for (int k = 0; k < N_CH; k++) begin
        wr_slow(k, (k % 2) ? vals[j] : vals[i]);
        wr_fast(k, (k % 2) ? vals[i] : vals[j]);
      end
      fast_edge();
      for (int k = 0; k < N_CH; k++)
        check("R4 saturating sum", code_of(k),
              exp_code((k % 2) ? vals[j] : vals[i], (k % 2) ? vals[i] : vals[j], 1'b1));
    end

    // R2 shadow holds until fast edge, all channels together
    for (int k = 0; k < N_CH; k++) begin wr_slow(k, 1000 * k); wr_fast(k, 5); end
    fast_edge();
    for (int k = 0; k < N_CH; k++) wr_fast(k, -7000 - k);
    repeat (20) @(negedge clk);
    for (int k = 0; k < N_CH; k++) check("R2 no change before edge", code_of(k), exp_code(1000 * k, 5, 1));
    @(negedge clk);
    fast_clk_in = 1;
    repeat (6) @(negedge clk);
    for (int k = 0; k < N_CH; k++) check("R2 all channels after edge", code_of(k), exp_code(1000 * k, -7000 - k, 1));
    fast_clk_in = 0; edges++;
    repeat (4) @(negedge clk);

    // R3 slow write without fast edge
    wr_slow(2, 40000);
    repeat (2) @(negedge clk);
    check("R3 slow applies directly", code_of(2), exp_code(40000, -7002, 1));

    // R5 disable and re-enable
    ch_en[5] = 0;
    wr_slow(5, 2222);
    repeat (3) @(negedge clk);
    check("R5 disabled at mid-scale", code_of(5), 524288);
    check("R5 neighbour unaffected", code_of(4), exp_code(4000, -7004, 1));
    ch_en[5] = 1;
    repeat (3) @(negedge clk);
    check("R5 values kept after re-enable", code_of(5), exp_code(2222, -7005, 1));

    // R6/R7 waveform playback
    for (int a = 0; a < 5; a++) begin
      @(negedge clk);
      wave_we = 1; wave_waddr = 8'(a); wave_wdata = DW'(a * 1000 - 2000);
    end
    @(negedge clk);
    wave_we = 0; wave_len = 3; wave_sel = 8'b0000_0001;
    wr_slow(0, 10);
    repeat (3) @(negedge clk);
    check("R6 sample zero before trigger", code_of(0), exp_code(10, 0, 1));
    @(negedge clk); slow_trig = 1; @(negedge clk); slow_trig = 0;
    for (int n = 0; n < 7; n++) begin
      fast_edge();
      check("R7 playback wraps at length", code_of(0), exp_code(10, (n % 3) * 1000 - 2000, 1));
      check("R6 unselected channel keeps fast term", code_of(1), exp_code(1000, -7001, 1));
    end
    @(negedge clk); slow_trig = 1; @(negedge clk); slow_trig = 0;
    repeat (3) @(negedge clk);
    check("R6 retrigger clears sample", code_of(0), exp_code(10, 0, 1));
    fast_edge();
    check("R6 retrigger starts at entry 0", code_of(0), exp_code(10, -2000, 1));

    // R8 heartbeat
    check("R8 heartbeat counts edges", int'(hb_count), edges);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule